// File: doc/BRIEF.md
# Dual-Range Programmable Loop Divider

This block sits in the feedback path of a frequency synthesizer. It takes an input clock that is already digital and counts it down by a 16-bit programmable ratio N. For every N input cycles it produces one single-cycle pulse, which goes to the phase comparator. A parallel configuration word sets the ratio, and two range flags set how the word is read. In the two upper ranges every bit of the word counts toward N. In the lowest range the four least significant bits are dropped, so the ratio is bits 15:4. Each range has its own legal minimum. A ratio below that minimum is raised to the minimum and a flag reports the clamp.

A configuration is written into a shadow register with a one-cycle load strobe. It only reaches the counter at terminal count, or when the divider is armed, so an output period is never cut short or stretched. The divider counts only while the run input is high. When run is low, the counter is frozen and the two port-select outputs, which tell the front end which input path is in use, are both inactive. When run goes high again, the count restarts from the full ratio.

Top module: `prog_ratio_divider`

## Requirements
- R1: After reset, and until a configuration has been loaded, `div_pulse`, `fm_port_en`, `am_port_en` and `clamp_flag` are all 0, whatever the value of `run_en`.
- R2: With `cfg_wide`=1 (`cfg_aux` ignored), N is the full 16-bit `cfg_word`, `fm_port_en`=1 and `am_port_en`=0 while the divider runs.
- R3: With `cfg_wide`=0 and `cfg_aux`=1, N is the full 16-bit `cfg_word`, `am_port_en`=1 and `fm_port_en`=0 while the divider runs.
- R4: With `cfg_wide`=0 and `cfg_aux`=0, N is `cfg_word[15:4]`, bits 3:0 have no effect, `am_port_en`=1 and `fm_port_en`=0 while the divider runs.
- R5: In the two full-word ranges, an N below 272 is used as 272. In the low range, an N below 4 is used as 4. `clamp_flag` is 1 while a clamped ratio is in use and 0 otherwise.
- R6: Count the rising edges with `run_en`=1 from the edge that arms the divider, starting at 1. `div_pulse` is 1 after edge k exactly when k is a multiple of N, so the pulse is one cycle wide and repeats every N cycles.
- R7: A configuration loaded while the divider runs does not change the period in progress, nor the port selects or the clamp flag. It takes effect from the edge that follows the next pulse.
- R8: One edge after `run_en` is sampled 0, `div_pulse`, both port selects and `clamp_flag` are 0 and counting stops. When `run_en` returns to 1, the first pulse follows exactly N enabled edges later.
- R9: A configuration loaded while `run_en`=0 is accepted and used as soon as the divider is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digitized input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration |
| cfg_word | input | 16 | Ratio word, bit 15 most significant |
| cfg_wide | input | 1 | Selects the full-word range on the high-frequency port |
| cfg_aux | input | 1 | When `cfg_wide`=0, selects the full-word range (1) or the shifted low range (0) |
| run_en | input | 1 | Divider enable; 0 freezes the count |
| div_pulse | output | 1 | One cycle high every N input cycles |
| fm_port_en | output | 1 | High-frequency input path in use |
| am_port_en | output | 1 | Low-frequency input path in use |
| clamp_flag | output | 1 | Ratio in use was raised to the range minimum |

## Verification
A configuration strobe is captured on the next edge, and the first enabled edge after that both arms the counter and sets the port selects and the clamp flag. Those outputs are therefore sampled at the falling edge that follows the arming edge. The bench keeps a count of enabled edges and expects a pulse after every edge whose number is a multiple of N. It samples at the falling edge after each rising edge, so each result is read one register stage after its cause. A mid-period reload is expected to change the outputs only on the edge after the next pulse. Disabling is expected to silence all outputs one edge after `run_en` is sampled low.

// File: rtl/prdiv_pkg.sv
package prdiv_pkg;

  typedef enum logic [1:0] {
    RANGE_LOW  = 2'd0,
    RANGE_MID  = 2'd1,
    RANGE_HIGH = 2'd2
  } range_e;

  function automatic range_e pick_range(input logic wide, input logic aux);
    if (wide)     return RANGE_HIGH;
    else if (aux) return RANGE_MID;
    else          return RANGE_LOW;
  endfunction

endpackage

// File: rtl/prdiv_reset_sync.sv
module prdiv_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) sync_q[0] <= 1'b0;
          else           sync_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) sync_q[i] <= 1'b0;
          else           sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/prdiv_cfg_shadow.sv
module prdiv_cfg_shadow #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] word_i,
  input  logic               wide_i,
  input  logic               aux_i,
  output logic [RATIO_W-1:0] word_o,
  output logic               wide_o,
  output logic               aux_o,
  output logic               valid_o
);
  logic [RATIO_W-1:0] word_q, word_d;
  logic               wide_q, wide_d;
  logic               aux_q, aux_d;
  logic               valid_q, valid_d;

  always_comb begin
    word_d  = word_i;
    wide_d  = wide_i;
    aux_d   = aux_i;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      wide_q  <= 1'b0;
      aux_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      word_q  <= word_d;
      wide_q  <= wide_d;
      aux_q   <= aux_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign wide_o  = wide_q;
  assign aux_o   = aux_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/prdiv_range_decode.sv
module prdiv_range_decode
  import prdiv_pkg::*;
#(
  parameter int RATIO_W   = 16,
  parameter int LOW_SHIFT = 4,
  parameter int HI_MIN    = 272,
  parameter int LO_MIN    = 4
) (
  input  logic [RATIO_W-1:0] word_i,
  input  logic               wide_i,
  input  logic               aux_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               clamp_o,
  output range_e             range_o
);
  localparam logic [RATIO_W-1:0] HI_MIN_V = RATIO_W'(HI_MIN);
  localparam logic [RATIO_W-1:0] LO_MIN_V = RATIO_W'(LO_MIN);

  logic [RATIO_W-1:0] low_raw;
  logic [RATIO_W-1:0] raw;
  logic [RATIO_W-1:0] floor_v;
  range_e             rng;

  generate
    if (LOW_SHIFT > 0) begin : g_shift
      assign low_raw = {{LOW_SHIFT{1'b0}}, word_i[RATIO_W-1:LOW_SHIFT]};
    end else begin : g_noshift
      assign low_raw = word_i;
    end
  endgenerate

  always_comb begin
    rng     = pick_range(wide_i, aux_i);
    raw     = (rng == RANGE_LOW) ? low_raw : word_i;
    floor_v = (rng == RANGE_LOW) ? LO_MIN_V : HI_MIN_V;
    clamp_o = (raw < floor_v);
    ratio_o = clamp_o ? floor_v : raw;
    range_o = rng;
  end
endmodule

// File: rtl/prdiv_counter.sv
module prdiv_counter
  import prdiv_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               clamp_i,
  input  range_e             range_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] act_n_o,
  output logic               armed_o,
  output logic               pulse_o,
  output logic               fm_en_o,
  output logic               am_en_o,
  output logic               clamp_o
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] act_n_q;
  logic               act_clamp_q;
  range_e             act_range_q;
  logic               armed_q, armed_d;
  logic               active;
  logic               reload_en;
  logic               dec_en;
  logic               cnt_en;
  logic               armed_en;

  always_comb begin
    active    = valid_i && run_i;
    reload_en = active && (!armed_q || (cnt_q == ONE));
    dec_en    = active && armed_q && (cnt_q != ONE);
    cnt_en    = reload_en || dec_en || !valid_i;
    armed_en  = reload_en || !active;
    armed_d   = reload_en;
    if (!valid_i)       cnt_d = '0;
    else if (reload_en) cnt_d = ratio_i;
    else                cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_n_q     <= '0;
      act_clamp_q <= 1'b0;
      act_range_q <= RANGE_LOW;
    end else if (reload_en) begin
      act_n_q     <= ratio_i;
      act_clamp_q <= clamp_i;
      act_range_q <= range_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign act_n_o = act_n_q;
  assign armed_o = armed_q;
  assign pulse_o = armed_q && (cnt_q == ONE);
  assign fm_en_o = armed_q && (act_range_q == RANGE_HIGH);
  assign am_en_o = armed_q && (act_range_q != RANGE_HIGH);
  assign clamp_o = armed_q && act_clamp_q;
endmodule

// File: rtl/prog_ratio_divider.sv
module prog_ratio_divider
  import prdiv_pkg::*;
#(
  parameter int RATIO_W     = 16,
  parameter int LOW_SHIFT   = 4,
  parameter int HI_MIN      = 272,
  parameter int LO_MIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [RATIO_W-1:0] cfg_word,
  input  logic               cfg_wide,
  input  logic               cfg_aux,
  input  logic               run_en,
  output logic               div_pulse,
  output logic               fm_port_en,
  output logic               am_port_en,
  output logic               clamp_flag
);
  logic               rst_sync_n;
  logic [RATIO_W-1:0] sh_word;
  logic               sh_wide;
  logic               sh_aux;
  logic               sh_valid;
  logic [RATIO_W-1:0] dec_ratio;
  logic               dec_clamp;
  range_e             dec_range;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] act_n;
  logic               armed;

  prdiv_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  prdiv_cfg_shadow #(.RATIO_W(RATIO_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (cfg_load),
    .word_i  (cfg_word),
    .wide_i  (cfg_wide),
    .aux_i   (cfg_aux),
    .word_o  (sh_word),
    .wide_o  (sh_wide),
    .aux_o   (sh_aux),
    .valid_o (sh_valid)
  );

  prdiv_range_decode #(
    .RATIO_W   (RATIO_W),
    .LOW_SHIFT (LOW_SHIFT),
    .HI_MIN    (HI_MIN),
    .LO_MIN    (LO_MIN)
  ) u_decode (
    .word_i  (sh_word),
    .wide_i  (sh_wide),
    .aux_i   (sh_aux),
    .ratio_o (dec_ratio),
    .clamp_o (dec_clamp),
    .range_o (dec_range)
  );

  prdiv_counter #(.RATIO_W(RATIO_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid_i (sh_valid),
    .run_i   (run_en),
    .ratio_i (dec_ratio),
    .clamp_i (dec_clamp),
    .range_i (dec_range),
    .cnt_o   (cnt),
    .act_n_o (act_n),
    .armed_o (armed),
    .pulse_o (div_pulse),
    .fm_en_o (fm_port_en),
    .am_en_o (am_port_en),
    .clamp_o (clamp_flag)
  );
endmodule

// File: rtl/prdiv_checker.sv
module prdiv_checker #(
  parameter int RATIO_W = 16,
  parameter int HI_MIN  = 272,
  parameter int LO_MIN  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_en,
  input logic               sh_valid,
  input logic               armed,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] act_n,
  input logic               div_pulse,
  input logic               fm_port_en,
  input logic               am_port_en,
  input logic               clamp_flag
);
  AST_UNLOADED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_valid |-> !(div_pulse || fm_port_en || am_port_en || clamp_flag)); // R1
  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fm_port_en && am_port_en)); // R2
  AST_HIGH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    fm_port_en |-> (act_n >= RATIO_W'(HI_MIN))); // R5
  AST_ANY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (act_n >= RATIO_W'(LO_MIN))); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R6
  AST_COUNT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt >= RATIO_W'(1) && cnt <= act_n)); // R6
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cnt != RATIO_W'(1)) |=> $stable(act_n)); // R7
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !(div_pulse || fm_port_en || am_port_en || clamp_flag)); // R8
endmodule

bind prog_ratio_divider prdiv_checker #(
  .RATIO_W (RATIO_W),
  .HI_MIN  (HI_MIN),
  .LO_MIN  (LO_MIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run_en     (run_en),
  .sh_valid   (sh_valid),
  .armed      (armed),
  .cnt        (cnt),
  .act_n      (act_n),
  .div_pulse  (div_pulse),
  .fm_port_en (fm_port_en),
  .am_port_en (am_port_en),
  .clamp_flag (clamp_flag)
);

// File: tb/sim_prog_ratio_divider.sv
module sim_prog_ratio_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [15:0] cfg_word;
  logic        cfg_wide;
  logic        cfg_aux;
  logic        run_en;
  logic        div_pulse;
  logic        fm_port_en;
  logic        am_port_en;
  logic        clamp_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prog_ratio_divider u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load   (cfg_load),
    .cfg_word   (cfg_word),
    .cfg_wide   (cfg_wide),
    .cfg_aux    (cfg_aux),
    .run_en     (run_en),
    .div_pulse  (div_pulse),
    .fm_port_en (fm_port_en),
    .am_port_en (am_port_en),
    .clamp_flag (clamp_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int outs();
    return {28'd0, div_pulse, fm_port_en, am_port_en, clamp_flag};
  endfunction

  task automatic load_cfg(input logic [15:0] w, input logic wd, input logic ax);
    cfg_word = w; cfg_wide = wd; cfg_aux = ax; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Load while stopped (R9), run, compare pulse train and status, then stop (R8).
  task automatic exercise(input string req, input logic [15:0] w, input logic wd,
                          input logic ax, input int n, input int clamp, input int cycles);
    int fm_exp;
    int bad;
    fm_exp = wd ? 1 : 0;
    bad = 0;
    run_en = 1'b0;
    @(negedge clk);
    load_cfg(w, wd, ax);
    run_en = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk({req, " R9 fm select"}, fm_port_en, fm_exp);
        chk({req, " am select"}, am_port_en, 1 - fm_exp);
        chk({req, " R5 clamp"}, clamp_flag, clamp);
      end
      if (div_pulse != ((k % n) == 0)) begin
        bad++;
        if (bad < 4) chk({req, " R6 pulse"}, div_pulse, ((k % n) == 0) ? 1 : 0);
      end
    end
    if (bad == 0) chk({req, " R6 pulse train"}, 0, 0);
    run_en = 1'b0;
    @(negedge clk);
    chk({req, " R8 outputs quiet"}, outs(), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = '0; cfg_wide = 1'b0;
    cfg_aux = 1'b0; run_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", outs(), 0);
    run_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (outs() != 0) chk("R1 unloaded run", outs(), 0);
    end
    chk("R1 unloaded run quiet", outs(), 0);

    // R4 low range sweep, low nibble noise must not matter
    for (int n = 0; n <= 40; n++) begin
      int en;
      en = (n < 4) ? 4 : n;
      exercise("R4", 16'((n << 4) | ((n * 7) & 15)), 1'b0, 1'b0, en, (n < 4) ? 1 : 0, 3 * en + 2);
    end
    exercise("R4 max", 16'hFFFF, 1'b0, 1'b0, 4095, 0, 2 * 4095 + 3);

    // R2 and R3 full-word ranges around the floor
    begin
      int vals[7] = '{0, 100, 271, 272, 273, 301, 1000};
      foreach (vals[i]) begin
        int en;
        en = (vals[i] < 272) ? 272 : vals[i];
        exercise("R2", 16'(vals[i]), 1'b1, vals[i][0], en, (vals[i] < 272) ? 1 : 0, 2 * en + 3);
        exercise("R3", 16'(vals[i]), 1'b0, 1'b1, en, (vals[i] < 272) ? 1 : 0, 2 * en + 3);
      end
    end

    // R7 reload mid-period: 300 wide, then 500 mid loaded during the first period
    run_en = 1'b0;
    @(negedge clk);
    load_cfg(16'd300, 1'b1, 1'b0);
    run_en = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int k = 1; k <= 1400; k++) begin
        int exp_p;
        @(negedge clk);
        if (k == 100) begin
          cfg_word = 16'd500; cfg_wide = 1'b0; cfg_aux = 1'b1; cfg_load = 1'b1;
        end else cfg_load = 1'b0;
        exp_p = (k == 300 || (k > 300 && ((k - 300) % 500) == 0)) ? 1 : 0;
        if (div_pulse != exp_p) begin
          bad++;
          if (bad < 4) chk("R7 pulse", div_pulse, exp_p);
        end
        if (k == 200) chk("R7 old port held", fm_port_en, 1);
        if (k == 300) chk("R7 old port at pulse", fm_port_en, 1);
        if (k == 301) chk("R7 new port", am_port_en, 1);
      end
      if (bad == 0) chk("R7 pulse train", 0, 0);
    end

    // R8 pause mid-count, then restart from full ratio (low range N=50)
    run_en = 1'b0;
    @(negedge clk);
    load_cfg(16'd50 << 4, 1'b0, 1'b0);
    run_en = 1'b1;
    repeat (120) @(negedge clk);
    run_en = 1'b0;
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (outs() != 0) bad++;
      end
      chk("R8 paused outputs", bad, 0);
      run_en = 1'b1;
      bad = 0;
      for (int k = 1; k <= 100; k++) begin
        @(negedge clk);
        if (div_pulse != ((k % 50) == 0)) bad++;
      end
      chk("R8 restart period", bad, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule